// File: doc/BRIEF.md
# Smart Card Waiting Time Counter

This block times the gaps between events on a smart card line. A wide down counter measures the answer-to-reset window and the character and block waiting times. It counts either elementary time unit (ETU) ticks or card clock ticks. Software starts it with a command, or every received start bit restarts it. When it reaches zero it raises a sticky time-out flag and an interrupt. Both stay set until the host reads the status register.

A second, short counter enforces the block guard time. It is loaded when the last character of a received block ends. Its length depends on the selected protocol: 16 ETU for T=0 and 22 ETU for T=1. A transmit request that arrives while it is non-zero is held back. It is released one clock after the guard count reaches zero.

A small byte-wide register port stages the load value, sets the mode and reports count and status. The character transmitter and receiver are outside the block. They supply the tick, start-bit and end-of-character strobes and consume the transmit release.

Top module: `sc_wait_timer`

## Requirements
- R1: After reset the count reads zero, the status register reads 0x00, irq is low and tx_go is low.
- R2: A write to the control register (address 3) with bit 0 set copies the staged load value into the counter and starts it. With a load value N of 1 or more, the counter decrements once per selected tick and expires on the N-th tick. Expiry is visible the cycle after that tick is sampled.
- R3: Control bit 3 selects the tick source: 0 counts etu_tick pulses only, 1 counts cclk_tick pulses only.
- R4: On expiry the counter stops, status bit 0 (time-out) and irq go high, and both stay high until the status register (address 3) is read with reg_rd. The read clears them.
- R5: With control bit 2 set, every start_bit pulse reloads the counter from the load value and runs it. With bit 2 clear, start_bit pulses have no effect on the count.
- R6: In restart mode with load value L, start bits spaced L-1 ticks apart never cause a time-out. The time-out occurs L ticks after the last start bit.
- R7: Writing the load value bytes (addresses 0 to 2, least significant byte at address 0) while the counter runs does not change the running count. The new value is used at the next start event.
- R8: An rx_char_end pulse loads the guard counter with 16 ETU when control bit 4 is 0 (T=0) and with 22 ETU when it is 1 (T=1). Status bit 2 is high while the guard count is non-zero.
- R9: A tx_req pulse while the guard is busy is held. tx_go pulses one cycle, two cycles after the final guard tick is sampled. With the guard idle, tx_go pulses the cycle after tx_req.
- R10: Control bit 1 stops the counter without setting the time-out flag and holds the count. Status bit 1 shows the running state.
- R11: Reads of addresses 0 to 2 return the current count bytes, least significant first. A read of address 3 returns {5'b0, guard busy, running, time-out}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| etu_tick | input | 1 | One-cycle pulse per elementary time unit |
| cclk_tick | input | 1 | One-cycle pulse per card clock cycle |
| start_bit | input | 1 | Pulse when a received start bit is detected |
| rx_char_end | input | 1 | Pulse at the end of the last received character |
| tx_req | input | 1 | Pulse requesting a transmission |
| tx_go | output | 1 | One-cycle release of a transmit request |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears the time-out on a status read) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| irq | output | 1 | Time-out interrupt, held until the status read |

## Verification
The bench builds the block with its default parameters: a 24-bit counter and guard lengths of 16 and 22 ETU. It uses small load values, so that expiry, reload on start bits and the held transmit release all occur within a few hundred cycles. Because the full guard lengths are used, the bench observes the exact boundary between the last guard tick and the transmit release for both protocol settings. The upper count bytes stay zero, so the wide counter is exercised through its low byte and its reload and stop paths.

// File: rtl/sc_wt_pkg.sv
package sc_wt_pkg;
    // control register bits
    localparam int CTL_GO      = 0;
    localparam int CTL_STOP    = 1;
    localparam int CTL_RESTART = 2;
    localparam int CTL_CCLK    = 3;
    localparam int CTL_T1      = 4;

    typedef struct packed {
        logic restart;
        logic cclk_sel;
        logic t1;
    } wt_mode_t;
endpackage

// File: rtl/sc_wt_regs.sv
module sc_wt_regs
    import sc_wt_pkg::*;
#(
    parameter int CNT_W  = 24,
    parameter int NBYTES = 3,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              expire,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              running,
    input  logic              guard_busy,
    output logic [CNT_W-1:0]  load_val,
    output wt_mode_t          mode,
    output logic              go,
    output logic              stop,
    output logic              flag
);
    localparam int PAD_W = NBYTES * 8;
    localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(NBYTES);

    typedef struct packed {
        logic [PAD_W-1:0] load;
        wt_mode_t         mode;
        logic             flag;
    } regs_t;

    regs_t st_d, st_q;
    logic  ctl_wr, stat_rd;
    logic [PAD_W-1:0] cnt_pad;

    always_comb begin
        ctl_wr  = reg_wr && (reg_addr == STAT_ADDR);
        stat_rd = reg_rd && (reg_addr == STAT_ADDR);
        cnt_pad = PAD_W'(cnt);
        st_d    = st_q;
        for (int i = 0; i < NBYTES; i++) begin
            if (reg_wr && reg_addr == ADDR_W'(i))
                st_d.load[i*8 +: 8] = reg_wdata;
        end
        if (ctl_wr) begin
            st_d.mode.restart  = reg_wdata[CTL_RESTART];
            st_d.mode.cclk_sel = reg_wdata[CTL_CCLK];
            st_d.mode.t1       = reg_wdata[CTL_T1];
        end
        st_d.flag = expire || (st_q.flag && !stat_rd);

        reg_rdata = 8'h00;
        for (int i = 0; i < NBYTES; i++) begin
            if (reg_addr == ADDR_W'(i))
                reg_rdata = cnt_pad[i*8 +: 8];
        end
        if (reg_addr == STAT_ADDR)
            reg_rdata = {5'b0, guard_busy, running, st_q.flag};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign load_val = st_q.load[CNT_W-1:0];
    assign mode     = st_q.mode;
    assign go       = ctl_wr && reg_wdata[CTL_GO];
    assign stop     = ctl_wr && reg_wdata[CTL_STOP];
    assign flag     = st_q.flag;
endmodule

// File: rtl/sc_wt_counter.sv
module sc_wt_counter #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             etu_tick,
    input  logic             cclk_tick,
    input  logic             start_bit,
    input  logic             go,
    input  logic             stop,
    input  logic             restart,
    input  logic             cclk_sel,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             running,
    output logic             expire,
    output logic             start_ev
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             run;
    } ctr_t;

    ctr_t st_d, st_q;
    logic tick;

    always_comb begin
        st_d     = st_q;
        expire   = 1'b0;
        tick     = cclk_sel ? cclk_tick : etu_tick;
        start_ev = go || (restart && start_bit);
        if (stop) begin
            st_d.run = 1'b0;
        end else if (start_ev) begin
            st_d.cnt = load_val;
            st_d.run = 1'b1;
        end else if (st_q.run && tick) begin
            if (st_q.cnt <= CNT_W'(1)) begin
                st_d.cnt = '0;
                st_d.run = 1'b0;
                expire   = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt     = st_q.cnt;
    assign running = st_q.run;
endmodule

// File: rtl/sc_wt_guard.sv
module sc_wt_guard #(
    parameter int BGT_T0 = 16,
    parameter int BGT_T1 = 22
) (
    input  logic clk,
    input  logic rst_n,
    input  logic etu_tick,
    input  logic rx_char_end,
    input  logic t1,
    input  logic tx_req,
    output logic tx_go,
    output logic guard_busy
);
    localparam int GMAX = (BGT_T1 > BGT_T0) ? BGT_T1 : BGT_T0;
    localparam int GW   = $clog2(GMAX + 1);

    typedef struct packed {
        logic [GW-1:0] gcnt;
        logic          pend;
        logic          go;
    } grd_t;

    grd_t st_d, st_q;
    logic pend;

    always_comb begin
        st_d = st_q;
        if (rx_char_end)
            st_d.gcnt = t1 ? GW'(BGT_T1) : GW'(BGT_T0);
        else if (etu_tick && st_q.gcnt != '0)
            st_d.gcnt = st_q.gcnt - GW'(1);
        pend = st_q.pend || tx_req;
        if (pend && st_q.gcnt == '0) begin
            st_d.go   = 1'b1;
            st_d.pend = 1'b0;
        end else begin
            st_d.go   = 1'b0;
            st_d.pend = pend;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tx_go      = st_q.go;
    assign guard_busy = st_q.gcnt != '0;
endmodule

// File: rtl/sc_wait_timer.sv
module sc_wait_timer
    import sc_wt_pkg::*;
#(
    parameter  int CNT_W  = 24,
    parameter  int BGT_T0 = 16,
    parameter  int BGT_T1 = 22,
    localparam int NBYTES = (CNT_W + 7) / 8,
    localparam int ADDR_W = $clog2(NBYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              etu_tick,
    input  logic              cclk_tick,
    input  logic              start_bit,
    input  logic              rx_char_end,
    input  logic              tx_req,
    output logic              tx_go,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              irq
);
    logic [CNT_W-1:0] load_val, cnt;
    wt_mode_t         mode;
    logic go, stop, flag, running, expire, start_ev, guard_busy;

    sc_wt_regs #(.CNT_W(CNT_W), .NBYTES(NBYTES), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .expire(expire), .cnt(cnt), .running(running),
        .guard_busy(guard_busy), .load_val(load_val), .mode(mode),
        .go(go), .stop(stop), .flag(flag)
    );

    sc_wt_counter #(.CNT_W(CNT_W)) u_ctr (
        .clk(clk), .rst_n(rst_n),
        .etu_tick(etu_tick), .cclk_tick(cclk_tick), .start_bit(start_bit),
        .go(go), .stop(stop), .restart(mode.restart), .cclk_sel(mode.cclk_sel),
        .load_val(load_val), .cnt(cnt), .running(running),
        .expire(expire), .start_ev(start_ev)
    );

    sc_wt_guard #(.BGT_T0(BGT_T0), .BGT_T1(BGT_T1)) u_grd (
        .clk(clk), .rst_n(rst_n), .etu_tick(etu_tick),
        .rx_char_end(rx_char_end), .t1(mode.t1), .tx_req(tx_req),
        .tx_go(tx_go), .guard_busy(guard_busy)
    );

    assign irq = flag;
endmodule

// File: rtl/sc_wt_chk.sv
module sc_wt_chk #(
    parameter int CNT_W  = 24,
    parameter int ADDR_W = 2,
    parameter int NBYTES = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_rd,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              irq,
    input logic              expire,
    input logic              stop,
    input logic              start_ev,
    input logic              running,
    input logic [CNT_W-1:0]  cnt,
    input logic              rx_char_end,
    input logic              guard_busy,
    input logic              tx_go
);
    // R4: the interrupt holds until a status read
    a_r4_irq_held: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !(reg_rd && reg_addr == ADDR_W'(NBYTES)) |=> irq);

    // R4: expiry raises the interrupt
    a_r4_expire_irq: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> irq);

    // R10: the counter leaves the running state only on expiry or stop
    a_r10_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(running) |-> $past(expire || stop));

    // R2: without a start event the running count never grows
    a_r2_no_count_up: assert property (@(posedge clk) disable iff (!rst_n)
        running && $past(running) && !$past(start_ev) |-> cnt <= $past(cnt));

    // R8: an end-of-character pulse makes the guard busy
    a_r8_guard_load: assert property (@(posedge clk) disable iff (!rst_n)
        rx_char_end |=> guard_busy);

    // R9: a transmit release only follows an idle guard
    a_r9_go_idle: assert property (@(posedge clk) disable iff (!rst_n)
        tx_go |-> $past(!guard_busy));
endmodule

bind sc_wait_timer sc_wt_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .NBYTES(NBYTES)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .irq(irq), .expire(expire), .stop(stop), .start_ev(start_ev),
    .running(running), .cnt(cnt), .rx_char_end(rx_char_end),
    .guard_busy(guard_busy), .tx_go(tx_go)
);

// File: tb/sc_wait_timer_bench.sv
module sc_wait_timer_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic etu_tick = 1'b0, cclk_tick = 1'b0, start_bit = 1'b0;
    logic rx_char_end = 1'b0, tx_req = 1'b0;
    logic reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic tx_go, irq;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    logic irq_prev = 1'b0;

    typedef struct {
        int    kind;   // 0: irq rise, 1: tx_go pulse
        int    cyc;
        string req;
    } ev_t;
    ev_t sb[$];

    sc_wait_timer u_sc_wait_timer (
        .clk(clk), .rst_n(rst_n), .etu_tick(etu_tick), .cclk_tick(cclk_tick),
        .start_bit(start_bit), .rx_char_end(rx_char_end), .tx_req(tx_req),
        .tx_go(tx_go), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic push(input int kind, input int off, input string req);
        ev_t e;
        e.kind = kind;
        e.cyc  = cyc + off;
        e.req  = req;
        sb.push_back(e);
    endtask

    // monitor: pops the scoreboard on each observed event
    task automatic note(input int kind);
        ev_t e;
        total++;
        if (sb.size() == 0) begin
            bad++;
            $display("FAIL unexpected event kind=%0d actual=%0d expected=none", kind, cyc);
        end else begin
            e = sb.pop_front();
            if (e.kind != kind || e.cyc != cyc) begin
                bad++;
                $display("FAIL %s event actual=%0d@%0d expected=%0d@%0d",
                         e.req, kind, cyc, e.kind, e.cyc);
            end
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (irq && !irq_prev) note(0);
            if (tx_go) note(1);
        end
        irq_prev = irq;
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [7:0] exp, input string req);
        logic [7:0] v;
        rd(a, v);
        chk(v == exp, req, v, exp);
    endtask

    // n ETU ticks four cycles apart; optional event pushed before the last one
    task automatic etu(input int n, input int kind, input int off, input string req);
        for (int i = 0; i < n; i++) begin
            if (i == n - 1 && kind >= 0) push(kind, off, req);
            etu_tick = 1'b1;
            @(negedge clk);
            etu_tick = 1'b0;
            repeat (3) @(negedge clk);
        end
    endtask

    task automatic cck(input int n, input int kind, input string req);
        for (int i = 0; i < n; i++) begin
            if (i == n - 1 && kind >= 0) push(kind, 1, req);
            cclk_tick = 1'b1;
            @(negedge clk);
            cclk_tick = 1'b0;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse_sb();
        start_bit = 1'b1; @(negedge clk); start_bit = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state, R11 layout
        chk(irq == 1'b0 && tx_go == 1'b0, "R1 outputs", {irq, tx_go}, 0);
        rd_chk(2'd3, 8'h00, "R1 status");
        rd_chk(2'd0, 8'h00, "R1 count byte0");
        rd_chk(2'd2, 8'h00, "R11 count byte2");

        // R2 software start, expiry on the N-th ETU tick
        wr(2'd0, 8'd5);
        wr(2'd3, 8'h01);
        rd_chk(2'd3, 8'h02, "R10 running bit");
        etu(4, -1, 0, "");
        rd_chk(2'd0, 8'd1, "R2 count after 4 ticks");
        chk(irq == 1'b0, "R2 no early expiry", irq, 0);
        etu(1, 0, 1, "R2 expiry tick");
        // R4 sticky flag cleared by status read
        chk(irq == 1'b1, "R4 irq held", irq, 1);
        rd_chk(2'd3, 8'h01, "R4 status flag");
        rd_chk(2'd3, 8'h00, "R4 flag cleared");
        chk(irq == 1'b0, "R4 irq cleared", irq, 0);

        // R3 card clock source
        wr(2'd0, 8'd7);
        wr(2'd3, 8'h09);
        etu(3, -1, 0, "");
        rd_chk(2'd0, 8'd7, "R3 ETU ignored in card clock mode");
        cck(7, 0, "R3 card clock expiry");
        rd_chk(2'd3, 8'h01, "R3 status");

        // R5/R6 restart on start bits
        wr(2'd0, 8'd12);
        wr(2'd3, 8'h04);
        for (int k = 0; k < 5; k++) begin
            pulse_sb();
            etu(11, -1, 0, "");
        end
        rd_chk(2'd3, 8'h02, "R6 still running, no time-out");
        pulse_sb();
        rd_chk(2'd0, 8'd12, "R5 start bit reloads");
        etu(12, 0, 1, "R6 time-out after last start bit");
        rd_chk(2'd3, 8'h01, "R6 status");

        // R5 one-shot ignores start bits, R10 stop
        wr(2'd3, 8'h00);
        wr(2'd0, 8'd10);
        wr(2'd3, 8'h01);
        etu(6, -1, 0, "");
        pulse_sb();
        rd_chk(2'd0, 8'd4, "R5 start bit ignored in one-shot");
        wr(2'd3, 8'h02);
        rd_chk(2'd3, 8'h00, "R10 stopped without flag");
        etu(6, -1, 0, "");
        rd_chk(2'd0, 8'd4, "R10 count held after stop");

        // R7 load change while running
        wr(2'd0, 8'd20);
        wr(2'd3, 8'h01);
        etu(3, -1, 0, "");
        wr(2'd0, 8'd5);
        etu(2, -1, 0, "");
        rd_chk(2'd0, 8'd15, "R7 running count unaffected");
        wr(2'd3, 8'h01);
        rd_chk(2'd0, 8'd5, "R7 new value at next start");
        etu(5, 0, 1, "R7 expiry from new value");
        rd_chk(2'd3, 8'h01, "R7 status");

        // R8/R9 guard, T=0
        wr(2'd3, 8'h00);
        rx_char_end = 1'b1; @(negedge clk); rx_char_end = 1'b0;
        rd_chk(2'd3, 8'h04, "R8 guard busy T=0");
        tx_req = 1'b1; @(negedge clk); tx_req = 1'b0;
        etu(15, -1, 0, "");
        rd_chk(2'd3, 8'h04, "R8 guard busy after 15 ETU");
        etu(1, 1, 2, "R9 release after 16 ETU");
        rd_chk(2'd3, 8'h00, "R8 guard idle T=0");

        // R8/R9 guard, T=1
        wr(2'd3, 8'h10);
        rx_char_end = 1'b1; @(negedge clk); rx_char_end = 1'b0;
        tx_req = 1'b1; @(negedge clk); tx_req = 1'b0;
        etu(21, -1, 0, "");
        rd_chk(2'd3, 8'h04, "R8 guard busy after 21 ETU");
        etu(1, 1, 2, "R9 release after 22 ETU");

        // R9 idle guard releases at once
        push(1, 1, "R9 idle release");
        tx_req = 1'b1; @(negedge clk); tx_req = 1'b0;
        repeat (4) @(negedge clk);

        chk(sb.size() == 0, "R9 all expected events seen", sb.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule